// File: doc/BRIEF.md
# Double-Buffered SPI Master Transmitter

This block is an SPI master with a one-byte transmit queue in front of its shift register. Software writes a byte into the data register. The byte waits there until the shift register is free and then moves across, so software can queue the next byte while the current one is still on the wire. When a byte is waiting at the end of a transfer, it starts shifting on the very next SCK edge slot, so a burst of bytes has no idle gap.

Each completed byte is copied from MISO into a receive register and raises a receive-full flag. Software releases that flag with a status read followed by a data read. If another byte completes while the flag is still set, an overrun flag is set and the older byte is kept. SCK polarity, clock phase, a power-of-two clock divider and two interrupt enables live in a control register. The two interrupt request outputs follow the transmit-empty and receive-full flags, each gated by its own enable.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, the status register reads 8'h01 (transmit-empty set, receive-full, overrun and busy clear), the control register reads 8'h00, SCK is low and both interrupt requests are low. Address map: 0 = data, 1 = status, 2 = control.
- R2: A data write while transmit-empty (status bit 0) is 1 loads the queue and clears the flag at the next clock edge. A data write while the flag is 0 is ignored: the queued byte is kept and the ignored byte never appears on MOSI.
- R3: A queued byte enters the shift register one clock after it is written if the shifter is idle. Transmit-empty is set again at that moment and busy (status bit 3) is 1 while the byte is shifting.
- R4: A byte queued during a transfer starts on the SCK slot right after the last edge of the current byte, so the spacing between sampling edges stays one SCK period across byte boundaries.
- R5: Each byte is sent on MOSI most significant bit first, eight bits per byte.
- R6: When the eighth bit is sampled, the MISO byte is stored in the receive register (read at address 0) and receive-full (status bit 1) is set.
- R7: Receive-full clears only when a data read follows a status read that saw the flag set. A data read alone leaves the flag set.
- R8: A byte that completes while receive-full is set sets overrun (status bit 2) and leaves the receive register holding the older byte. The clearing sequence of R7 also clears overrun.
- R9: Control bit 1 sets the SCK idle level (polarity) and control bit 0 selects the phase. With phase 0, data is sampled on the leading edge of each bit; with phase 1, it is sampled on the trailing edge. All four combinations exchange bytes correctly.
- R10: Control bits 6:4 hold a rate value r. Each SCK half-period is 2^r system clocks, so the reset value gives SCK at half the system clock.
- R11: The transmit interrupt equals transmit-empty ANDed with control bit 2, and the receive interrupt equals receive-full ANDed with control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; triggers read side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| irq_tx | output | 1 | Transmit-empty interrupt request |
| irq_rx | output | 1 | Receive-full interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A data write changes transmit-empty at the clock edge that accepts it. The byte is taken into the shifter at the next edge, so the bench reads status right after the write and again one cycle later. At the fastest rate, the first SCK edge follows the take by one clock and receive-full rises sixteen SCK ticks after that. The bench therefore waits a margin of whole cycles, or waits on the interrupt pins, before it reads the receive side, and it never relies on polling that could arm the clear sequence by accident. A slave model timestamps every sampling edge and checks that consecutive edges within a burst are exactly one SCK period apart. It also pops the expected MOSI bytes from a scoreboard queue as each eighth bit arrives.

// File: rtl/spi_dbuf_pkg.sv
// spi_dbuf_pkg: register addresses and bit positions shared by the SPI master
// and its bench-facing documentation. Assumes a 2-bit register address.
package spi_dbuf_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

    // status bit positions
    localparam int ST_TXE  = 0;
    localparam int ST_RXF  = 1;
    localparam int ST_OVR  = 2;
    localparam int ST_BUSY = 3;

    // control bit positions
    localparam int CT_PHASE = 0;
    localparam int CT_POL   = 1;
    localparam int CT_TXIE  = 2;
    localparam int CT_RXIE  = 3;
    localparam int CT_RATE  = 4;
endpackage

// File: rtl/spi_rate_gen.sv
// spi_rate_gen: emits a one-cycle tick every 2^rate system clocks while run
// is high. Assumes run is low for at least one cycle before a new burst, and
// that the counter restarts from zero there.
module spi_rate_gen #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = (1 << RATE_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // limit is the half-period minus one
    always_comb limit = CNT_W'((1 << rate) - 1);

    assign tick = run && (cnt == limit);

    // count system clocks inside each half-period
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_shifter.sv
// spi_shifter: the serial engine. It takes a byte from the queue when idle, or
// on the last edge of the current byte, and drives SCK/MOSI while it samples
// MISO. Assumes one tick per SCK edge and that phase/polarity are held
// constant during a transfer.
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phase,
    input  logic         pol,
    input  logic         tick,
    input  logic         q_valid,
    input  logic [W-1:0] q_data,
    input  logic         miso,
    output logic         busy,
    output logic         take,
    output logic         done,
    output logic [W-1:0] rx_byte,
    output logic         sck,
    output logic         mosi
);
    localparam int EDGES = 2 * W;
    localparam int EC_W  = $clog2(EDGES);
    localparam logic [EC_W-1:0] LAST = EC_W'(EDGES - 1);

    logic [EC_W-1:0] ecnt;
    logic [W-1:0]    tx_sr;
    logic [W-1:0]    rx_sr;
    logic            sck_q;
    logic            last_edge;

    assign last_edge = busy && tick && (ecnt == LAST);
    assign done      = last_edge;
    assign take      = q_valid && (!busy || last_edge);
    assign sck       = busy ? sck_q : pol;
    // with phase 1 the final bit is sampled on the completing edge itself
    assign rx_byte   = phase ? {rx_sr[W-2:0], miso} : rx_sr;

    // load, shift and sample on each SCK edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            ecnt  <= '0;
            sck_q <= 1'b0;
            mosi  <= 1'b0;
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (take) begin
            busy  <= 1'b1;
            ecnt  <= '0;
            sck_q <= pol;
            if (!phase) begin
                mosi  <= q_data[W-1];
                tx_sr <= q_data << 1;
            end else begin
                tx_sr <= q_data;
            end
        end else if (done) begin
            busy  <= 1'b0;
            ecnt  <= '0;
            sck_q <= pol;
        end else if (busy && tick) begin
            sck_q <= ~sck_q;
            ecnt  <= ecnt + 1'b1;
            if (!ecnt[0] == !phase) begin
                // leading edge with phase 0, trailing edge with phase 1: sample
                rx_sr <= {rx_sr[W-2:0], miso};
            end else begin
                mosi  <= tx_sr[W-1];
                tx_sr <= tx_sr << 1;
            end
        end
    end
endmodule

// File: rtl/spi_regs.sv
// spi_regs: the register side. It holds the transmit queue, receive register,
// flags and control, and applies the two-step receive clear. Assumes the bus
// strobes are single-cycle pulses and that read data is taken combinationally.
module spi_regs
    import spi_dbuf_pkg::*;
#(
    parameter int W      = 8,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              take,
    input  logic              done,
    input  logic              busy,
    input  logic [W-1:0]      rx_byte,
    output logic              q_valid,
    output logic [W-1:0]      tx_buf,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              ovr,
    output logic [W-1:0]      rx_reg,
    output logic              phase,
    output logic              pol,
    output logic [RATE_W-1:0] rate,
    output logic              irq_tx,
    output logic              irq_rx
);
    localparam int CTRL_W = CT_RATE + RATE_W;

    logic [CTRL_W-1:0] ctrl;
    logic              arm;
    logic              wr_data, wr_ctrl, rd_data, rd_stat, clr;
    logic [W-1:0]      status;

    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign rd_data = bus_rd && (bus_addr == A_DATA);
    assign rd_stat = bus_rd && (bus_addr == A_STAT);
    assign clr     = rd_data && arm;

    assign phase   = ctrl[CT_PHASE];
    assign pol     = ctrl[CT_POL];
    assign rate    = ctrl[CT_RATE +: RATE_W];
    assign q_valid = !tx_empty;
    assign irq_tx  = tx_empty && ctrl[CT_TXIE];
    assign irq_rx  = rx_full && ctrl[CT_RXIE];

    // assemble the status word
    always_comb begin
        status          = '0;
        status[ST_TXE]  = tx_empty;
        status[ST_RXF]  = rx_full;
        status[ST_OVR]  = ovr;
        status[ST_BUSY] = busy;
    end

    // read data mux
    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = rx_reg;
            A_STAT:  bus_rdata = status;
            A_CTRL:  bus_rdata = W'(ctrl);
            default: bus_rdata = '0;
        endcase
    end

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= '0;
        else if (wr_ctrl) ctrl <= bus_wdata[CTRL_W-1:0];
    end

    // transmit queue: accept only while empty, refill flag on take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf   <= '0;
            tx_empty <= 1'b1;
        end else if (wr_data && tx_empty) begin
            tx_buf   <= bus_wdata;
            tx_empty <= 1'b0;
        end else if (take) begin
            tx_empty <= 1'b1;
        end
    end

    // receive register, receive-full, overrun and the clear sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_reg  <= '0;
            rx_full <= 1'b0;
            ovr     <= 1'b0;
            arm     <= 1'b0;
        end else begin
            if (clr) begin
                rx_full <= 1'b0;
                ovr     <= 1'b0;
                arm     <= 1'b0;
            end else if (rd_stat && rx_full) begin
                arm <= 1'b1;
            end
            if (done) begin
                if (rx_full && !clr) begin
                    ovr <= 1'b1;
                end else begin
                    rx_reg  <= rx_byte;
                    rx_full <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_dbuf_master.sv
// spi_dbuf_master: top of the double-buffered SPI master. It connects the
// register side, the rate generator and the shifter. Assumes a single master
// on the bus and a slave that follows the programmed phase and polarity.
module spi_dbuf_master #(
    parameter int W      = 8,
    parameter int RATE_W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq_tx,
    output logic         irq_rx,
    output logic         sck,
    output logic         mosi,
    input  logic         miso
);
    logic              take, done, busy, tick, q_valid;
    logic              tx_empty, rx_full, ovr, phase, pol;
    logic [W-1:0]      tx_buf, rx_reg, rx_byte;
    logic [RATE_W-1:0] rate;

    spi_regs #(.W(W), .RATE_W(RATE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .take(take), .done(done), .busy(busy), .rx_byte(rx_byte),
        .q_valid(q_valid), .tx_buf(tx_buf), .tx_empty(tx_empty),
        .rx_full(rx_full), .ovr(ovr), .rx_reg(rx_reg), .phase(phase),
        .pol(pol), .rate(rate), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    spi_rate_gen #(.RATE_W(RATE_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(busy), .rate(rate), .tick(tick)
    );

    spi_shifter #(.W(W)) u_shift (
        .clk(clk), .rst_n(rst_n), .phase(phase), .pol(pol), .tick(tick),
        .q_valid(q_valid), .q_data(tx_buf), .miso(miso), .busy(busy),
        .take(take), .done(done), .rx_byte(rx_byte), .sck(sck), .mosi(mosi)
    );
endmodule

// File: rtl/spi_dbuf_master_chk.sv
// spi_dbuf_master_chk: temporal checks on the SPI master, bound to the top.
module spi_dbuf_master_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   bus_addr,
    input logic         bus_wr,
    input logic         bus_rd,
    input logic         tx_empty,
    input logic [W-1:0] tx_buf,
    input logic         rx_full,
    input logic         ovr,
    input logic [W-1:0] rx_reg,
    input logic         take,
    input logic         done,
    input logic         busy,
    input logic         sck,
    input logic         pol,
    input logic         irq_tx,
    input logic         irq_rx
);
    logic data_wr, data_rd;
    assign data_wr = bus_wr && (bus_addr == 2'd0);
    assign data_rd = bus_rd && (bus_addr == 2'd0);

    assert_accept_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && tx_empty) |=> !tx_empty);
    assert_ignore_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !tx_empty) |=> $stable(tx_buf));
    assert_take_refills_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (tx_empty && busy));
    assert_rx_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rx_full) |=> rx_full);
    assert_clear_needs_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(data_rd));
    assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full && !data_rd) |=> (ovr && $stable(rx_reg)));
    assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == pol));
    assert_irq_tx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> tx_empty);
    assert_irq_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> rx_full);
endmodule

bind spi_dbuf_master spi_dbuf_master_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .tx_empty(tx_empty), .tx_buf(tx_buf), .rx_full(rx_full),
    .ovr(ovr), .rx_reg(rx_reg), .take(take), .done(done), .busy(busy),
    .sck(sck), .pol(pol), .irq_tx(irq_tx), .irq_rx(irq_rx)
);

// File: tb/spi_dbuf_master_bench.sv
`timescale 1ns/1ps
module spi_dbuf_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_tx, irq_rx, sck, mosi, miso;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spi_dbuf_master u_spi_dbuf_master (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- slave model and scoreboard ----------------
    logic [7:0] exp_mosi[$];
    int         nbytes = 0;
    logic [2:0] bidx = '0;
    logic [7:0] cap = '0;
    bit         m_phase = 0, m_pol = 0;
    realtime    last_t = 0, period = 16;
    bit         gap_on = 0;

    function automatic logic [7:0] slave_byte(input int n);
        return 8'(8'h5A + n * 8'h1D);
    endfunction

    assign miso = slave_byte(nbytes)[3'd7 - bidx];

    // monitor: capture MOSI at sampling edges, pop and compare whole bytes
    always @(sck) begin
        if (rst_n) begin
            bit lead;
            bit samp;
            lead = (sck != m_pol);
            samp = m_phase ? !lead : lead;
            if (samp) begin
                if (gap_on && last_t > 0)
                    check(($realtime - last_t) == period, "R4/R10 edge spacing",
                          32'($realtime - last_t), 32'(period));
                last_t = $realtime;
                cap = {cap[6:0], mosi};
                if (bidx == 3'd7) begin
                    if (exp_mosi.size() == 0) begin
                        check(0, "R2/R5 unexpected MOSI byte", cap, 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_mosi.pop_front();
                        check(cap == e, "R5 MOSI byte MSB first", cap, e);
                    end
                    nbytes++;
                end
                bidx = bidx + 3'd1;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // data write that the bench expects to be accepted
    task automatic send(input logic [7:0] d);
        exp_mosi.push_back(d);
        wr(2'd0, d);
    endtask

    task automatic set_mode(input bit ph, input bit po, input int r, input bit ie);
        m_phase = ph; m_pol = po;
        period = 2 * (1 << r) * 8;
        last_t = 0;
        gap_on = 1;
        wr(2'd2, 8'((r << 4) | (ie ? 12 : 0) | (po << 1) | ph));
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // single byte in one mode, checked end to end
    task automatic one_byte(input bit ph, input bit po, input int r, input logic [7:0] d);
        logic [7:0] v;
        int k;
        set_mode(ph, po, r, 0);
        check(sck == po, "R9 SCK idle level", sck, po);
        k = nbytes;
        send(d);
        wait_cycles(2 + 34 * (1 << r));
        rd(2'd1, v);
        check(v == 8'h03, "R6 status after byte", v, 8'h03);
        rd(2'd0, v);
        check(v == slave_byte(k), "R9 received byte", v, slave_byte(k));
        rd(2'd1, v);
        check(v == 8'h01, "R7 cleared after sequence", v, 8'h01);
    endtask

    initial begin
        #200000;
        check(0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, v); check(v == 8'h01, "R1 status reset", v, 8'h01);
        rd(2'd2, v); check(v == 8'h00, "R1 control reset", v, 8'h00);
        check(sck == 1'b0, "R1 sck idle", sck, 0);
        check(!irq_tx && !irq_rx, "R1 irqs low", {irq_tx, irq_rx}, 0);

        // phase 0, polarity 0, fastest rate, interrupts enabled
        set_mode(0, 0, 0, 1);
        check(irq_tx == 1'b1, "R11 irq_tx with enable", irq_tx, 1);
        k = nbytes;
        send(8'h3C);
        rd(2'd1, v); check(v[0] == 1'b0, "R2 write clears tx-empty", v[0], 0);
        rd(2'd1, v); check(v[3:0] == 4'b1001, "R3 taken, busy, tx-empty", v[3:0], 4'b1001);
        send(8'h81);
        rd(2'd1, v); check(v[0] == 1'b0, "R2 queued while busy", v[0], 0);
        wr(2'd0, 8'hFF);   // ignored: queue full
        wait_cycles(60);
        check(nbytes == k + 2, "R2 ignored byte not sent", nbytes - k, 2);
        check(irq_rx == 1'b1, "R11 irq_rx with enable", irq_rx, 1);
        rd(2'd0, v); check(v == slave_byte(k), "R6 first byte received", v, slave_byte(k));
        check(irq_rx == 1'b1, "R7 data read alone keeps full", irq_rx, 1);
        rd(2'd1, v); check(v == 8'h07, "R8 overrun flagged", v, 8'h07);
        rd(2'd0, v); check(v == slave_byte(k), "R8 older byte kept", v, slave_byte(k));
        rd(2'd1, v); check(v == 8'h01, "R7 two-step clear", v, 8'h01);
        check(irq_rx == 1'b0, "R11 irq_rx drops", irq_rx, 0);

        // phase 1, polarity 0, rate 1: three-byte burst
        set_mode(1, 0, 1, 1);
        k = nbytes;
        send(8'hA7);
        while (!irq_tx) @(negedge clk);
        send(8'h10);
        for (int i = 0; i < 3; i++) begin
            while (!irq_rx) @(negedge clk);
            rd(2'd1, v); check(v[1] == 1'b1, "R6 full in burst", v[1], 1);
            rd(2'd0, v); check(v == slave_byte(k + i), "R6 burst byte", v, slave_byte(k + i));
            if (i == 0) begin
                while (!irq_tx) @(negedge clk);
                send(8'hE2);
            end
        end
        rd(2'd1, v); check(v[2:1] == 2'b00, "R8 no overrun in burst", v[2:1], 0);

        // interrupts disabled
        set_mode(0, 0, 0, 0);
        check(irq_tx == 1'b0, "R11 irq_tx masked", irq_tx, 0);

        // remaining polarity/phase combinations and rates
        one_byte(0, 1, 2, 8'hC3);
        one_byte(1, 1, 0, 8'h5E);
        one_byte(0, 0, 3, 8'h96);

        wait_cycles(4);
        check(exp_mosi.size() == 0, "R5 all queued bytes sent", exp_mosi.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule